// File: doc/BRIEF.md
# NAND Sector Single-Error-Correcting Parity Engine

This block computes and checks a Hamming-style parity code over one 512-byte flash sector. Bytes arrive one per strobe. Every data bit has a 12-bit position: the byte offset (9 bits) above the bit index (3 bits). For each of the 12 position bits the engine keeps two parities. One covers the bits whose position has that bit set and the other covers the bits whose position has it clear. The parities sit in a 32-bit raw register that has two unused 4-bit gaps. At the end of the sector that register is packed into a 24-bit code and inverted, so an erased sector (all 0xFF) gives the code 0xFFFFFF. The code is then shifted out one byte at a time, least significant byte first.

During a read the host streams the sector through the engine in the same way. It then presents the code that was stored with the sector. The engine XORs the stored code with the freshly computed one and classifies the difference. The result is clean, a correctable single data-bit error (with the byte offset and bit index to flip), an error confined to the stored code, or uncorrectable. The engine is a small state machine with four states. S_IDLE waits. S_ACCUM takes data bytes. S_EMIT drives the three code bytes. S_REPORT presents a check result for one cycle. The transitions are as follows. start moves the engine from any state to S_ACCUM. In S_ACCUM, done moves it to S_EMIT once 512 bytes have been taken. S_EMIT returns to S_IDLE after its third byte. chk_req moves S_IDLE to S_REPORT while a code is held. S_REPORT always returns to S_IDLE.

All outputs are registered. A response appears in the cycle after the clock edge that samples the stimulus.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset, code_valid, code_byte_valid and stat_valid are all low.
- R2: A start pulse, in any state and even partway through a sector, clears the parity state and the byte count, drops code_valid and puts the engine in S_ACCUM. Only bytes that follow it contribute to the code.
- R3: Give data bit b of byte n the position p = 8n + b. Code bit k (k = 0..11) is the inverse of the XOR of all data bits whose p has bit k clear. Code bit 12+k is the inverse of the XOR of all data bits whose p has bit k set.
- R4: A sector of 512 bytes of 0xFF yields code_word 0xFFFFFF.
- R5: done sampled after exactly 512 data strobes latches code_word and raises code_valid in the next cycle. code_byte_valid is then high for three consecutive cycles carrying code bits 7:0, then 15:8, then 23:16.
- R6: A check result is shown by stat_valid high for one cycle, in the cycle after chk_req is sampled. The status encoding is 0 clean, 1 data bit corrected, 2 error in stored code, 3 uncorrectable. Equal stored and computed codes give status 0.
- R7: When the stored and computed codes differ in a way that marks one data bit, the status is 1. err_offset gives that bit's byte offset and err_bit its bit index.
- R8: When the codes differ in exactly one bit and that difference does not mark a data bit, the status is 2 and err_offset and err_bit are 0.
- R9: Any other nonzero difference gives status 3. This includes two flipped data bits and a marked byte offset that is not below the sector size.
- R10: done sampled before 512 data strobes have been taken is ignored: no code bytes are emitted and the sector continues.
- R11: Data strobes after the 512th byte of a sector are ignored and do not change the code.
- R12: chk_req is ignored unless the engine is in S_IDLE and holds a code: no stat_valid follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new sector: clear parity state |
| data_valid | input | 1 | data_in holds a sector byte this cycle |
| data_in | input | 8 | Sector byte |
| done | input | 1 | End of sector: latch and emit the code |
| chk_req | input | 1 | Compare chk_code with the held code |
| chk_code | input | 24 | Code stored with the sector |
| code_valid | output | 1 | code_word holds the code of the last sector |
| code_word | output | 24 | Packed, inverted parity code |
| code_byte_valid | output | 1 | code_byte holds one code byte |
| code_byte | output | 8 | Code byte, least significant first |
| stat_valid | output | 1 | Check result valid this cycle |
| status | output | 2 | Check result class |
| err_offset | output | 9 | Byte offset of the bit to flip |
| err_bit | output | 3 | Bit index of the bit to flip |

## Verification
The hardest results to produce from the ports are the correctable-error and stored-code-error outcomes. They need a stored code that differs from the freshly computed one in one of a few specific patterns. The bench first streams a clean sector and records the code the engine emits. It then flips a single chosen bit in the same sector, streams it again and presents the recorded code. The bytes at offsets 0 and 511 and bits 0 and 7 are among the positions tried. To create a code-only error, the bench flips one bit of the freshly computed code instead. The bench also places done before the 512th byte and extra strobes after it, and it restarts in the middle of a sector.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int RAW_W    = 32;
    localparam int RAW_HALF = 16;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_DATA_FIX = 2'd1,
        ST_CODE_ERR = 2'd2,
        ST_UNCORR   = 2'd3
    } chk_status_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACCUM  = 2'd1,
        S_EMIT   = 2'd2,
        S_REPORT = 2'd3
    } eng_state_e;

endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
    import ecc_pkg::*;
#(
    parameter int OFS_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [7:0]           data,
    output logic [RAW_W-1:0]     raw
);
    localparam int AW = OFS_W + 3;

    function automatic logic [7:0] lane_mask(input int k);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
        return m;
    endfunction

    logic [AW-1:0] hi_q, lo_q;
    logic [AW-1:0] hi_t, lo_t;
    logic          byte_par;

    assign byte_par = ^data;

    genvar k;
    generate
        for (k = 0; k < AW; k++) begin : g_pos
            if (k < 3) begin : g_lane
                assign hi_t[k] = ^(data & lane_mask(k));
                assign lo_t[k] = ^(data & ~lane_mask(k));
            end else begin : g_ofs
                assign hi_t[k] = ofs[k-3]  & byte_par;
                assign lo_t[k] = ~ofs[k-3] & byte_par;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (clr) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (en) begin
            hi_q <= hi_q ^ hi_t;
            lo_q <= lo_q ^ lo_t;
        end
    end

    always_comb begin
        raw = '0;
        raw[AW-1:0]          = lo_q;
        raw[RAW_HALF +: AW]  = hi_q;
    end

endmodule

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
    import ecc_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [RAW_W-1:0]  raw,
    output logic [2*AW-1:0]   code
);
    logic unused_holes;
    assign unused_holes = ^{raw[RAW_HALF-1:AW], raw[RAW_W-1:RAW_HALF+AW]};

    assign code = ~{raw[RAW_HALF +: AW], raw[AW-1:0]};

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import ecc_pkg::*;
#(
    parameter int AW           = 12,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [2*AW-1:0] stored,
    input  logic [2*AW-1:0] computed,
    output logic [1:0]      status,
    output logic [AW-4:0]   ofs,
    output logic [2:0]      bitidx
);
    logic [2*AW-1:0] diff;
    logic [AW-1:0]   lo, hi;
    logic [AW-4:0]   ofs_mark;
    logic            complement;

    assign diff       = stored ^ computed;
    assign lo         = diff[AW-1:0];
    assign hi         = diff[2*AW-1:AW];
    assign ofs_mark   = hi[AW-1:3];
    assign complement = (lo ^ hi) == {AW{1'b1}};

    always_comb begin
        status = ST_CLEAN;
        ofs    = '0;
        bitidx = '0;
        if (diff == '0) begin
            status = ST_CLEAN;
        end else if (complement) begin
            if (32'(ofs_mark) < 32'(SECTOR_BYTES)) begin
                status = ST_DATA_FIX;
                ofs    = ofs_mark;
                bitidx = hi[2:0];
            end else begin
                status = ST_UNCORR;
            end
        end else if ($onehot(diff)) begin
            status = ST_CODE_ERR;
        end else begin
            status = ST_UNCORR;
        end
    end

endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              data_valid,
    input  logic [7:0]                        data_in,
    input  logic                              done,
    input  logic                              chk_req,
    input  logic [2*($clog2(SECTOR_BYTES)+3)-1:0] chk_code,
    output logic                              code_valid,
    output logic [2*($clog2(SECTOR_BYTES)+3)-1:0] code_word,
    output logic                              code_byte_valid,
    output logic [7:0]                        code_byte,
    output logic                              stat_valid,
    output logic [1:0]                        status,
    output logic [$clog2(SECTOR_BYTES)-1:0]   err_offset,
    output logic [2:0]                        err_bit
);
    localparam int OFS_W = $clog2(SECTOR_BYTES);
    localparam int AW    = OFS_W + 3;
    localparam int CW    = 2 * AW;
    localparam int NB    = (CW + 7) / 8;
    localparam int CNT_W = OFS_W + 1;
    localparam int EW    = (NB > 1) ? $clog2(NB) : 1;

    eng_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [EW-1:0]     emit_q;
    logic              have_code_q;
    logic [CW-1:0]     code_q;
    logic [1:0]        res_status_q;
    logic [OFS_W-1:0]  res_ofs_q;
    logic [2:0]        res_bit_q;

    logic              full;
    logic              acc_en;
    logic [RAW_W-1:0]  raw;
    logic [CW-1:0]     fresh_code;
    logic [1:0]        cls_status;
    logic [OFS_W-1:0]  cls_ofs;
    logic [2:0]        cls_bit;
    logic [NB*8-1:0]   code_pad;

    assign full   = cnt_q == CNT_W'(SECTOR_BYTES);
    assign acc_en = (state_q == S_ACCUM) && data_valid && !full && !start;

    ecc_parity_acc #(.OFS_W(OFS_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (acc_en),
        .ofs   (cnt_q[OFS_W-1:0]),
        .data  (data_in),
        .raw   (raw)
    );

    ecc_code_pack #(.AW(AW)) u_pack (
        .raw  (raw),
        .code (fresh_code)
    );

    ecc_classify #(.AW(AW), .SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .stored   (chk_code),
        .computed (code_q),
        .status   (cls_status),
        .ofs      (cls_ofs),
        .bitidx   (cls_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = S_ACCUM;
        end else begin
            unique case (state_q)
                S_IDLE:   if (chk_req && have_code_q) state_d = S_REPORT;
                S_ACCUM:  if (done && full)           state_d = S_EMIT;
                S_EMIT:   if (emit_q == EW'(NB-1))    state_d = S_IDLE;
                S_REPORT:                             state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            emit_q       <= '0;
            have_code_q  <= 1'b0;
            code_q       <= '0;
            res_status_q <= '0;
            res_ofs_q    <= '0;
            res_bit_q    <= '0;
        end else begin
            if (start)       cnt_q <= '0;
            else if (acc_en) cnt_q <= cnt_q + 1'b1;

            if (state_q == S_EMIT && state_d == S_EMIT) emit_q <= emit_q + 1'b1;
            else                                        emit_q <= '0;

            if (start) begin
                have_code_q <= 1'b0;
            end else if (state_q == S_ACCUM && state_d == S_EMIT) begin
                have_code_q <= 1'b1;
                code_q      <= fresh_code;
            end

            if (state_q == S_IDLE && state_d == S_REPORT) begin
                res_status_q <= cls_status;
                res_ofs_q    <= cls_ofs;
                res_bit_q    <= cls_bit;
            end
        end
    end

    // outputs
    assign code_pad = (NB*8)'(code_q);

    always_comb begin
        code_valid      = have_code_q;
        code_word       = code_q;
        code_byte_valid = (state_q == S_EMIT);
        code_byte       = code_pad[8*emit_q +: 8];
        stat_valid      = (state_q == S_REPORT);
        status          = res_status_q;
        err_offset      = res_ofs_q;
        err_bit         = res_bit_q;
    end

endmodule

// File: rtl/nand_ecc_corrector_chk.sv
module nand_ecc_corrector_chk #(
    parameter int CW    = 24,
    parameter int OFS_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             chk_req,
    input logic             code_valid,
    input logic [CW-1:0]    code_word,
    input logic             code_byte_valid,
    input logic [7:0]       code_byte,
    input logic             stat_valid,
    input logic [1:0]       status,
    input logic [OFS_W-1:0] err_offset,
    input logic [2:0]       err_bit
);
    logic unused_cb;
    assign unused_cb = ^code_byte;

    // R2: start drops code_valid
    a_r2_start_drops_code: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !code_valid);

    // R5: code bytes only while a code is held, and the word holds still
    a_r5_bytes_need_code: assert property (@(posedge clk) disable iff (!rst_n)
        code_byte_valid |-> code_valid);

    a_r5_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (code_byte_valid && $past(code_byte_valid)) |-> $stable(code_word));

    // R10: emission begins only after done was sampled
    a_r10_emit_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_byte_valid) |-> $past(done));

    // R12: a report follows a request
    a_r12_report_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(chk_req));

    // R8: no flip position unless a data bit is corrected
    a_r8_no_position: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && status != 2'd1) |-> (err_offset == '0 && err_bit == '0));

    // R6: reports last one cycle
    a_r6_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

endmodule

bind nand_ecc_corrector nand_ecc_corrector_chk #(.CW(CW), .OFS_W(OFS_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .done            (done),
    .chk_req         (chk_req),
    .code_valid      (code_valid),
    .code_word       (code_word),
    .code_byte_valid (code_byte_valid),
    .code_byte       (code_byte),
    .stat_valid      (stat_valid),
    .status          (status),
    .err_offset      (err_offset),
    .err_bit         (err_bit)
);

// File: tb/nand_ecc_corrector_test.sv
module nand_ecc_corrector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, data_valid = 1'b0, done = 1'b0, chk_req = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [23:0] chk_code = 24'h0;
    logic        code_valid, code_byte_valid, stat_valid;
    logic [23:0] code_word;
    logic [7:0]  code_byte;
    logic [1:0]  status;
    logic [8:0]  err_offset;
    logic [2:0]  err_bit;

    always #5 clk = ~clk;

    nand_ecc_corrector uut (
        .clk(clk), .rst_n(rst_n), .start(start), .data_valid(data_valid),
        .data_in(data_in), .done(done), .chk_req(chk_req), .chk_code(chk_code),
        .code_valid(code_valid), .code_word(code_word),
        .code_byte_valid(code_byte_valid), .code_byte(code_byte),
        .stat_valid(stat_valid), .status(status),
        .err_offset(err_offset), .err_bit(err_bit)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    logic        exp_cv = 0, exp_cbv = 0, exp_sv = 0;
    logic [23:0] exp_word = 0;
    logic [7:0]  exp_byte = 0;
    logic [1:0]  exp_st = 0;
    logic [8:0]  exp_ofs = 0;
    logic [2:0]  exp_bit = 0;

    logic [7:0]  sec [0:599];

    function automatic logic [23:0] model_code();
        logic [11:0] o, e;
        o = '0; e = '0;
        for (int i = 0; i < 512; i++)
            for (int b = 0; b < 8; b++)
                if (sec[i][b]) begin
                    int p;
                    p = i * 8 + b;
                    for (int k = 0; k < 12; k++)
                        if (((p >> k) & 1) == 1) o[k] = ~o[k];
                        else                     e[k] = ~e[k];
                end
        return ~{o, e};
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every output with the reference model once per clock
    task automatic step();
        @(negedge clk);
        n_cmp++;
        cmp("code_valid", 32'(code_valid), 32'(exp_cv));
        cmp("code_byte_valid", 32'(code_byte_valid), 32'(exp_cbv));
        cmp("stat_valid", 32'(stat_valid), 32'(exp_sv));
        if (exp_cv)  cmp("code_word", 32'(code_word), 32'(exp_word));
        if (exp_cbv) cmp("code_byte", 32'(code_byte), 32'(exp_byte));
        if (exp_sv) begin
            cmp("status", 32'(status), 32'(exp_st));
            cmp("err_offset", 32'(err_offset), 32'(exp_ofs));
            cmp("err_bit", 32'(err_bit), 32'(exp_bit));
        end
    endtask

    task automatic feed(input int nbytes, input int early_at, input bit probe);
        logic [23:0] c;
        start = 1; exp_cv = 0; step();
        start = 0;
        for (int i = 0; i < nbytes; i++) begin
            if (i == early_at) begin
                data_valid = 0; done = 1; step();   // R10: ignored
                done = 0;
            end
            data_valid = 1; data_in = sec[i % 600];
            chk_req = probe && (i == 10);           // R12: busy, ignored
            step();
        end
        data_valid = 0; chk_req = 0;
        c = model_code();
        done = 1; exp_cv = 1; exp_word = c; exp_cbv = 1; exp_byte = c[7:0]; step();
        done = 0; exp_byte = c[15:8];  step();
        exp_byte = c[23:16]; step();
        exp_cbv = 0; step();
    endtask

    task automatic check(input logic [23:0] stored, input logic [1:0] st,
                         input int ofs, input int bt);
        chk_req = 1; chk_code = stored;
        exp_sv = 1; exp_st = st; exp_ofs = 9'(ofs); exp_bit = 3'(bt);
        step();
        chk_req = 0; exp_sv = 0; step();
    endtask

    task automatic fill_pattern(input int seed);
        for (int i = 0; i < 600; i++) sec[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    bit finished = 0;

    initial begin
        logic [23:0] good;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cur_req = "R1"; step(); step();

        // R12: no code held yet
        cur_req = "R12"; chk_req = 1; chk_code = 24'h123456; step();
        chk_req = 0; step();

        // R4: erased sector
        cur_req = "R4";
        for (int i = 0; i < 600; i++) sec[i] = 8'hFF;
        feed(512, -1, 0);
        cur_req = "R4"; cmp("erased", 32'(code_word), 32'h00FFFFFF);

        // R3/R5: patterned sector, byte order
        cur_req = "R3"; fill_pattern(5); feed(512, -1, 0);
        cur_req = "R5"; fill_pattern(91); feed(512, -1, 1);   // also R12 probe
        good = model_code();

        // R6: clean compare
        cur_req = "R6"; check(good, 2'd0, 0, 0);

        // R7: single data-bit flips at several positions
        cur_req = "R7";
        sec[300] ^= 8'h20; feed(512, -1, 0); cur_req = "R7"; check(good, 2'd1, 300, 5);
        sec[300] ^= 8'h20; sec[0] ^= 8'h01; feed(512, -1, 0); check(good, 2'd1, 0, 0);
        sec[0] ^= 8'h01; sec[511] ^= 8'h80; feed(512, -1, 0); check(good, 2'd1, 511, 7);
        sec[511] ^= 8'h80;

        // R8: stored code differs in one bit
        cur_req = "R8"; feed(512, -1, 0);
        check(good ^ 24'h800000, 2'd2, 0, 0);
        check(good ^ 24'h000001, 2'd2, 0, 0);

        // R9: two data bits flipped
        cur_req = "R9";
        sec[3] ^= 8'h02; sec[400] ^= 8'h40; feed(512, -1, 0);
        check(good, 2'd3, 0, 0);
        sec[3] ^= 8'h02; sec[400] ^= 8'h40;

        // R10: early done ignored
        cur_req = "R10"; fill_pattern(17); feed(512, 100, 0);

        // R11: extra strobes ignored (model covers first 512 only)
        cur_req = "R11"; fill_pattern(53); feed(515, -1, 0);

        // R2: restart mid-sector
        cur_req = "R2";
        start = 1; exp_cv = 0; step(); start = 0;
        for (int i = 0; i < 50; i++) begin data_valid = 1; data_in = 8'h5A; step(); end
        data_valid = 0;
        fill_pattern(200); feed(512, -1, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule